// File: doc/BRIEF.md
# Per-Pin Drive Source Selector Array

This block holds one 8-bit control byte for each of a group of device-socket pins and turns it into the enable lines for the pin's drive sources. There are seven sources: a hard ground switch, the per-pin DAC output, the shared test supply, the logic-high driver, the logic-low driver, a pullup resistor and a pulldown resistor. A 2-bit mode field can connect the pin's logic drivers to the shared clock generator in either phase. Priority rules between conflicting sources are fixed in the decoder. Because of them, a "sticky" pulldown or pullup can stay set while other sources switch, and the pin does not glitch.

A host writes the control bytes through a simple synchronous write strobe. Each pin owns a 16-byte address window. A read from any address in a pin's window returns that pin's synchronised comparator level in bit 0. The array is built for 8 pins by default. Analog behaviour of the sources is outside this block.

Top module: `pin_source_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, every control byte clears to 0x00, so after that edge all enable outputs are 0.
- R2: A write (`bus_wr` high) with `bus_addr[6:4]` = pin index and `bus_addr[3:0]` equal to 0 or 1 loads `bus_wdata` into that pin's control byte at the clock edge. Other pins keep their bytes.
- R3: A write to offsets 2 to 15 of a pin window has no effect on any enable output.
- R4: Control bits 0, 1, 2 and 3 enable ground, DAC, test supply and logic high, in that order. The outputs are `en_gnd`, `en_dac`, `en_tst` and `en_hi`.
- R5: Mode field bits [6:5] select the logic drivers: 00 gives neither, 01 gives logic low, 10 gives `en_hi`=`clk_hi` and `en_lo`=`clk_lo`, and 11 swaps the phases, giving `en_hi`=`clk_lo` and `en_lo`=`clk_hi`.
- R6: Control bit 3 (high) overrides the mode field: `en_hi`=1 and `en_lo`=0. `en_hi` and `en_lo` of a pin are never both 1. If the mode routes both drivers on, high wins.
- R7: Bit 4 (pullup) dominates bit 7 (pulldown). With both set, `en_pu`=1 and `en_pd`=0.
- R8: Bit 0 (ground) suppresses both pull resistors. With ground set, `en_pu` and `en_pd` are 0.
- R9: The pulldown stays enabled alongside DAC, test, high or low sources. For example, 0x84 gives `en_pd`=1 and `en_tst`=1.
- R10: A read at any address in pin k's window returns `bus_rdata` = {7'b1111111, q}. Here q is `pin_cmp[k]` delayed through two flops (both cleared by reset), so a change appears in `bus_rdata` after the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 7 | Pin index [6:4], window offset [3:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed pin |
| clk_hi | input | 1 | Shared clock generator high-drive enable (true phase) |
| clk_lo | input | 1 | Shared clock generator low-drive enable (true phase) |
| pin_cmp | input | 8 | Asynchronous pin comparator results |
| en_gnd | output | 8 | Ground switch enable per pin |
| en_dac | output | 8 | DAC output enable per pin |
| en_tst | output | 8 | Test supply enable per pin |
| en_hi | output | 8 | Logic-high driver enable per pin |
| en_lo | output | 8 | Logic-low driver enable per pin |
| en_pu | output | 8 | Pullup enable per pin |
| en_pd | output | 8 | Pulldown enable per pin |

## Verification
The logic-high bit and the clock-routed logic drivers can both ask for a driver in the same cycle. So can the pullup and pulldown bits, under the ground switch. The bench sets the high bit together with low mode or a clock mode. It also drives `clk_hi` and `clk_lo` both high under clock mode, and writes combined pull and ground bytes. In each case it checks that exactly the dominant enable is present on the ports.

// File: rtl/pinsel_pkg.sv
// Shared types for the pin drive source selector.
// Assumes the control byte layout below; the field order is what the decoder reads.
package pinsel_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_CLK  = 2'b10,
        DRV_CLKN = 2'b11
    } drv_mode_e;

    typedef struct packed {
        logic      pd;
        drv_mode_e mode;
        logic      pu;
        logic      hi;
        logic      tst;
        logic      dac;
        logic      gnd;
    } pin_ctl_t;

    typedef struct packed {
        logic gnd;
        logic dac;
        logic tst;
        logic hi;
        logic lo;
        logic pu;
        logic pd;
    } pin_en_t;

endpackage

// File: rtl/pinsel_reg.sv
// One pin's control byte register.
// Loads on wr_en and clears on synchronous active-low reset.
module pinsel_reg
    import pinsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic [7:0] wdata,
    output pin_ctl_t ctl
);

    // Hold or load the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr_en)
            ctl <= pin_ctl_t'(wdata);
    end

endmodule

// File: rtl/pinsel_decode.sv
// Combinational decode of one control byte into source enables.
// Assumes clk_hi/clk_lo are the true-phase driver requests of the shared clock.
// Priorities: high over low, ground over pulls, pullup over pulldown.
module pinsel_decode
    import pinsel_pkg::*;
(
    input  pin_ctl_t ctl,
    input  logic     clk_hi,
    input  logic     clk_lo,
    output pin_en_t  en
);

    logic mode_hi;
    logic mode_lo;

    // Route the mode field onto raw logic driver requests.
    always_comb begin
        unique case (ctl.mode)
            DRV_OFF:  begin mode_hi = 1'b0;   mode_lo = 1'b0;   end
            DRV_LOW:  begin mode_hi = 1'b0;   mode_lo = 1'b1;   end
            DRV_CLK:  begin mode_hi = clk_hi; mode_lo = clk_lo; end
            DRV_CLKN: begin mode_hi = clk_lo; mode_lo = clk_hi; end
            default:  begin mode_hi = 1'b0;   mode_lo = 1'b0;   end
        endcase
    end

    // Apply the fixed source priorities.
    always_comb begin
        en.gnd = ctl.gnd;
        en.dac = ctl.dac;
        en.tst = ctl.tst;
        en.hi  = ctl.hi | mode_hi;
        en.lo  = mode_lo & ~en.hi;
        en.pu  = ctl.pu & ~ctl.gnd;
        en.pd  = ctl.pd & ~ctl.pu & ~ctl.gnd;
    end

endmodule

// File: rtl/pinsel_sync.sv
// Two-flop synchroniser for a vector of asynchronous comparator levels.
// Each bit is treated on its own; no cross-bit coherence is assumed.
module pinsel_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    // Shift the levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/pin_source_array.sv
// Array of per-pin drive source selectors on a byte-wide bus.
// Each pin owns a 2**OFS_W byte window; the control byte sits at offsets 0-1.
// Assumes at most one write per cycle and that reads need no strobe.
module pin_source_array
    import pinsel_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int OFS_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [$clog2(NPINS)+OFS_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 clk_hi,
    input  logic                 clk_lo,
    input  logic [NPINS-1:0]     pin_cmp,
    output logic [NPINS-1:0]     en_gnd,
    output logic [NPINS-1:0]     en_dac,
    output logic [NPINS-1:0]     en_tst,
    output logic [NPINS-1:0]     en_hi,
    output logic [NPINS-1:0]     en_lo,
    output logic [NPINS-1:0]     en_pu,
    output logic [NPINS-1:0]     en_pd
);

    localparam int IDX_W  = $clog2(NPINS);
    localparam int ADDR_W = IDX_W + OFS_W;

    logic [IDX_W-1:0] pin_idx;
    logic [OFS_W-1:0] pin_ofs;
    logic             ctl_slot;
    logic [NPINS-1:0] cmp_q;

    // Split the address into pin index and window offset.
    always_comb begin
        pin_idx  = bus_addr[ADDR_W-1:OFS_W];
        pin_ofs  = bus_addr[OFS_W-1:0];
        ctl_slot = ((pin_ofs >> 1) == '0);
    end

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        pin_ctl_t ctl;
        pin_en_t  en;
        logic     wr_hit;

        // Write decode for this pin's control byte.
        assign wr_hit = bus_wr && ctl_slot && (pin_idx == IDX_W'(k));

        pinsel_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_hit),
            .wdata (bus_wdata[7:0]),
            .ctl   (ctl)
        );

        pinsel_decode u_dec (
            .ctl    (ctl),
            .clk_hi (clk_hi),
            .clk_lo (clk_lo),
            .en     (en)
        );

        assign en_gnd[k] = en.gnd;
        assign en_dac[k] = en.dac;
        assign en_tst[k] = en.tst;
        assign en_hi[k]  = en.hi;
        assign en_lo[k]  = en.lo;
        assign en_pu[k]  = en.pu;
        assign en_pd[k]  = en.pd;
    end

    pinsel_sync #(.WIDTH(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_cmp),
        .q     (cmp_q)
    );

    // Readback: synchronised level in bit 0, ones above.
    always_comb begin
        bus_rdata = {{(DATA_W-1){1'b1}}, cmp_q[pin_idx]};
    end

    // R6: logic drivers of a pin never fight.
    a_r6_hi_lo_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi & en_lo) == '0);

    // R7: pull resistors never both on.
    a_r7_pu_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pu & en_pd) == '0);

    // R8: ground switch never shares the pin with a pull resistor.
    a_r8_gnd_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (en_gnd & (en_pu | en_pd)) == '0);

    // R1: reset leaves every pin undriven.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> ((en_gnd | en_dac | en_tst | en_hi | en_lo | en_pu | en_pd) == '0));

    // R3: writes outside the control slot leave the static enables alone.
    a_r3_ignored_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ctl_slot) |=> ($stable(en_gnd) && $stable(en_dac) && $stable(en_tst)
                                   && $stable(en_pu) && $stable(en_pd)));

endmodule

// File: tb/sim_pin_source_array.sv
module sim_pin_source_array;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       clk_hi = 1'b0;
    logic       clk_lo = 1'b0;
    logic [NPINS-1:0] pin_cmp = '0;
    logic [NPINS-1:0] en_gnd, en_dac, en_tst, en_hi, en_lo, en_pu, en_pd;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_source_array u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_hi(clk_hi),
        .clk_lo(clk_lo), .pin_cmp(pin_cmp), .en_gnd(en_gnd), .en_dac(en_dac),
        .en_tst(en_tst), .en_hi(en_hi), .en_lo(en_lo), .en_pu(en_pu), .en_pd(en_pd)
    );

    // Enable order {gnd,dac,tst,hi,lo,pu,pd}
    localparam logic [6:0] E_GND = 7'b1000000;
    localparam logic [6:0] E_DAC = 7'b0100000;
    localparam logic [6:0] E_TST = 7'b0010000;
    localparam logic [6:0] E_HI  = 7'b0001000;
    localparam logic [6:0] E_LO  = 7'b0000100;
    localparam logic [6:0] E_PU  = 7'b0000010;
    localparam logic [6:0] E_PD  = 7'b0000001;

    function automatic logic [6:0] pin_en(input int p);
        return {en_gnd[p], en_dac[p], en_tst[p], en_hi[p], en_lo[p], en_pu[p], en_pd[p]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_pin(input string req, input int p, input logic [6:0] exp);
        #1;
        chk(req, {1'b0, pin_en(p)}, {1'b0, exp});
    endtask

    task automatic wr(input int p, input int ofs, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = {3'(p), 4'(ofs)};
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int p = 0; p < NPINS; p++) chk_pin("R1 reset idle", p, 7'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_direct_bits;
        wr(0, 0, 8'h01); chk_pin("R4 ground", 0, E_GND);
        wr(0, 1, 8'h02); chk_pin("R4 dac via offset 1", 0, E_DAC);
        wr(0, 0, 8'h04); chk_pin("R4 test", 0, E_TST);
        wr(0, 0, 8'h08); chk_pin("R4 high", 0, E_HI);
        wr(0, 0, 8'h00); chk_pin("R4 all off", 0, 7'b0);
    endtask

    task automatic t_pin_select;
        wr(2, 0, 8'h01);
        wr(3, 0, 8'h02);
        chk_pin("R2 pin3 loaded", 3, E_DAC);
        chk_pin("R2 pin2 kept", 2, E_GND);
        chk_pin("R2 pin4 untouched", 4, 7'b0);
        wr(7, 1, 8'h04);
        chk_pin("R2 pin7 loaded", 7, E_TST);
    endtask

    task automatic t_offset_ignore;
        wr(3, 3, 8'hFF); chk_pin("R3 offset 3 ignored", 3, E_DAC);
        wr(3, 2, 8'h01); chk_pin("R3 offset 2 ignored", 3, E_DAC);
        wr(3, 15, 8'h84); chk_pin("R3 offset 15 ignored", 3, E_DAC);
    endtask

    task automatic t_mode;
        wr(1, 0, 8'h20); chk_pin("R5 mode low", 1, E_LO);
        wr(1, 0, 8'h40);
        clk_hi = 1'b1; clk_lo = 1'b0; chk_pin("R5 true clk high", 1, E_HI);
        clk_hi = 1'b0; clk_lo = 1'b1; chk_pin("R5 true clk low", 1, E_LO);
        clk_hi = 1'b0; clk_lo = 1'b0; chk_pin("R5 clk float", 1, 7'b0);
        wr(1, 0, 8'h60);
        clk_hi = 1'b1; clk_lo = 1'b0; chk_pin("R5 comp clk low", 1, E_LO);
        clk_hi = 1'b0; clk_lo = 1'b1; chk_pin("R5 comp clk high", 1, E_HI);
        clk_hi = 1'b0; clk_lo = 1'b0;
        wr(1, 0, 8'h00); chk_pin("R5 mode off", 1, 7'b0);
    endtask

    task automatic t_high_priority;
        wr(5, 0, 8'h28); chk_pin("R6 high over low mode", 5, E_HI);
        wr(5, 0, 8'h48);
        clk_hi = 1'b0; clk_lo = 1'b1; chk_pin("R6 high over clk low", 5, E_HI);
        wr(5, 0, 8'h40);
        clk_hi = 1'b1; clk_lo = 1'b1; chk_pin("R6 both requested", 5, E_HI);
        clk_hi = 1'b0; clk_lo = 1'b0;
    endtask

    task automatic t_pulls;
        wr(6, 0, 8'h10); chk_pin("R7 pullup", 6, E_PU);
        wr(6, 0, 8'h80); chk_pin("R7 pulldown", 6, E_PD);
        wr(6, 0, 8'h90); chk_pin("R7 pullup dominates", 6, E_PU);
        wr(6, 0, 8'h81); chk_pin("R8 ground clears pulldown", 6, E_GND);
        wr(6, 0, 8'h11); chk_pin("R8 ground clears pullup", 6, E_GND);
        wr(6, 0, 8'h84); chk_pin("R9 pulldown with test", 6, E_PD | E_TST);
        wr(6, 0, 8'hA0); chk_pin("R9 pulldown with low", 6, E_PD | E_LO);
        wr(6, 0, 8'h94); chk_pin("R9 pullup sheds pulldown", 6, E_PU | E_TST);
    endtask

    task automatic t_readback;
        @(negedge clk);
        bus_addr = {3'd4, 4'd9};
        pin_cmp = 8'b0001_0000;
        @(negedge clk); #1;
        chk("R10 one edge still old", bus_rdata, 8'hFE);
        @(negedge clk); #1;
        chk("R10 two edges new", bus_rdata, 8'hFF);
        bus_addr = {3'd4, 4'd0}; #1;
        chk("R10 other offset same", bus_rdata, 8'hFF);
        bus_addr = {3'd3, 4'd5}; #1;
        chk("R10 other pin low", bus_rdata, 8'hFE);
        pin_cmp = 8'h00;
    endtask

    initial begin
        t_reset;
        t_direct_bits;
        t_pin_select;
        t_offset_ignore;
        t_mode;
        t_high_priority;
        t_pulls;
        t_readback;
        wr(6, 0, 8'h10);
        t_reset;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule